// File: doc/BRIEF.md
# Rheostat Command Decoder and Register Set

This block sits behind the serial front end of a digitally programmed variable resistor. Each time the front end has a complete, validated 16-bit frame it pulses a strobe, and the block decodes the frame. It keeps the wiper code that drives the resistor ladder, a small control register and a shutdown flag. It also prepares the reply word that the front end shifts out during the next frame. Storing the wiper, refreshing the wiper and reading back a location or the last-used address are passed on as one-cycle requests to a separate nonvolatile memory controller. That controller reports back with a busy level, a program-success pulse and a data-return strobe.

A frame holds two reserved bits at the top, then a 4-bit command code at bits [13:10], then a 10-bit data field at bits [9:0]. Writes to the wiper and to memory are locked out after reset until software opens them through the control register. A small state machine has four states. In IDLE the block accepts frames. It moves to RESTORE_WAIT on an accepted refresh command, to MEMRD_WAIT on an accepted location read, and to ADDRRD_WAIT on an accepted last-address read. Each wait state returns to IDLE when the memory data-return strobe arrives.

Top module: `rheo_ctrl`

## Requirements
- R1: After reset the wiper holds mid-scale (512), shutdown is 0, the control bits are 0, the reply word is 0 and every memory request is low.
- R2: Command 1 loads data bits [9:0] into the wiper only while the write-enable bit C1 is 1. While C1 is 0 the wiper keeps its value.
- R3: Command 7 sets C0 from data bit 0 and C1 from data bit 1 and leaves C2 unchanged. C2 is set to 1 only by a pulse on mem_prog_ok. Command 8 makes the reply word equal to C2 in bit 3, 0 in bit 2, C1 in bit 1 and C0 in bit 0, with all upper bits 0.
- R4: Command 2 makes the reply word equal to the wiper code, zero-extended to 16 bits.
- R5: Command 3 raises store_req for exactly one cycle, but only while the program-enable bit C0 is 1.
- R6: Command 4 raises restore_req for one cycle, clears shutdown and moves to RESTORE_WAIT. The next mem_rvld loads mem_rdata into the wiper whatever the value of C1.
- R7: Command 5 raises read_req for one cycle and sets read_addr to data bits [5:0]. The next mem_rvld sets the reply word to mem_rdata, zero-extended.
- R8: Command 6 raises lastaddr_req for one cycle. The next mem_rvld sets the reply word to mem_rdata[5:0], zero-extended.
- R9: Command 9 sets shutdown to data bit 0. While shutdown is 1, all other commands still take effect.
- R10: While mem_busy is 1, commands 1, 3, 4, 5, 6, 7 and 9 change no state and raise no request. Commands 2 and 8 are still answered.
- R11: Codes 0 and 10 to 15, and any frame with a nonzero bit 15 or 14, act as no-operation. They change no state and set the reply word to 0. Every other accepted frame that is not a read also sets the reply word to 0.
- R12: A frame that arrives while the block waits for memory data is dropped. State and reply word stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_vld | input | 1 | One-cycle strobe: a complete frame is on word_in |
| word_in | input | 16 | Frame: reserved [15:14], command [13:10], data [9:0] |
| mem_busy | input | 1 | Memory controller is programming; register changes are locked out |
| mem_prog_ok | input | 1 | Pulse: a store completed successfully, sets C2 |
| mem_rvld | input | 1 | Pulse: mem_rdata carries the reply to the pending request |
| mem_rdata | input | 10 | Data returned by the memory controller |
| wiper | output | 10 | Wiper code for the resistor ladder |
| shutdown | output | 1 | Ladder open-circuit request |
| resp_word | output | 16 | Reply word for the next frame |
| store_req | output | 1 | Pulse: store the wiper code into memory |
| restore_req | output | 1 | Pulse: fetch the last stored code |
| read_req | output | 1 | Pulse: read the location on read_addr |
| read_addr | output | 6 | Location selected by the last read command |
| lastaddr_req | output | 1 | Pulse: report the last programmed address |

## Verification
The bench builds the block with its default parameters: a 10-bit wiper, a 6-bit location field and a mid-scale preset of 512. With these values the bench can use fixed frame encodings for every command, and it can tell a preset wiper apart from a written one or a restored one. The bench toggles mem_busy and sends frames during the memory wait states. These directed sequences reach the locked-out paths, the dropped-frame path and the rule that a refresh overrides write protection.

// File: rtl/rheo_pkg.sv
package rheo_pkg;

    typedef enum logic [3:0] {
        CMD_NOP      = 4'd0,
        CMD_WR_WIPER = 4'd1,
        CMD_RD_WIPER = 4'd2,
        CMD_STORE    = 4'd3,
        CMD_REFRESH  = 4'd4,
        CMD_RD_MEM   = 4'd5,
        CMD_RD_LAST  = 4'd6,
        CMD_WR_CTRL  = 4'd7,
        CMD_RD_CTRL  = 4'd8,
        CMD_SHDN     = 4'd9
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE         = 2'd0,
        ST_RESTORE_WAIT = 2'd1,
        ST_MEMRD_WAIT   = 2'd2,
        ST_ADDRRD_WAIT  = 2'd3
    } seq_e;

endpackage

// File: rtl/rheo_decode.sv
module rheo_decode
    import rheo_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic [DW+5:0] frame,
    output cmd_e          cmd,
    output logic [DW-1:0] data
);
    localparam int CMD_LSB = DW;

    logic [3:0] code;
    logic [1:0] rsvd;

    assign code = frame[CMD_LSB +: 4];
    assign rsvd = frame[CMD_LSB+4 +: 2];
    assign data = frame[DW-1:0];

    always_comb begin
        cmd = CMD_NOP;
        if (rsvd == 2'b00) begin
            case (code)
                4'd1:    cmd = CMD_WR_WIPER;
                4'd2:    cmd = CMD_RD_WIPER;
                4'd3:    cmd = CMD_STORE;
                4'd4:    cmd = CMD_REFRESH;
                4'd5:    cmd = CMD_RD_MEM;
                4'd6:    cmd = CMD_RD_LAST;
                4'd7:    cmd = CMD_WR_CTRL;
                4'd8:    cmd = CMD_RD_CTRL;
                4'd9:    cmd = CMD_SHDN;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/rheo_seq.sv
module rheo_seq
    import rheo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic word_vld,
    input  cmd_e cmd,
    input  logic mem_busy,
    input  logic mem_rvld,
    output logic idle,
    output logic done_restore,
    output logic done_memrd,
    output logic done_addrrd
);
    seq_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (word_vld && !mem_busy) begin
                    if (cmd == CMD_REFRESH)      state_nx = ST_RESTORE_WAIT;
                    else if (cmd == CMD_RD_MEM)  state_nx = ST_MEMRD_WAIT;
                    else if (cmd == CMD_RD_LAST) state_nx = ST_ADDRRD_WAIT;
                end
            end
            ST_RESTORE_WAIT, ST_MEMRD_WAIT, ST_ADDRRD_WAIT:
                if (mem_rvld) state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        idle         = (state == ST_IDLE);
        done_restore = (state == ST_RESTORE_WAIT) && mem_rvld;
        done_memrd   = (state == ST_MEMRD_WAIT)   && mem_rvld;
        done_addrrd  = (state == ST_ADDRRD_WAIT)  && mem_rvld;
    end
endmodule

// File: rtl/rheo_ctrl.sv
module rheo_ctrl
    import rheo_pkg::*;
#(
    parameter int DW  = 10,
    parameter int AW  = 6,
    parameter int MID = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          word_vld,
    input  logic [DW+5:0] word_in,
    input  logic          mem_busy,
    input  logic          mem_prog_ok,
    input  logic          mem_rvld,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] wiper,
    output logic          shutdown,
    output logic [DW+5:0] resp_word,
    output logic          store_req,
    output logic          restore_req,
    output logic          read_req,
    output logic [AW-1:0] read_addr,
    output logic          lastaddr_req
);
    localparam int WORD_W = DW + 6;

    cmd_e          cmd;
    logic [DW-1:0] data;
    logic          idle, done_restore, done_memrd, done_addrrd;
    logic          accept, open_gate;
    logic          ctl_prog_en, ctl_wr_en, ctl_prog_ok;

    rheo_decode #(.DW(DW)) u_dec (
        .frame (word_in),
        .cmd   (cmd),
        .data  (data)
    );

    rheo_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_vld     (word_vld),
        .cmd          (cmd),
        .mem_busy     (mem_busy),
        .mem_rvld     (mem_rvld),
        .idle         (idle),
        .done_restore (done_restore),
        .done_memrd   (done_memrd),
        .done_addrrd  (done_addrrd)
    );

    assign accept    = word_vld && idle;
    assign open_gate = !mem_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wiper        <= DW'(MID);
            shutdown     <= 1'b0;
            resp_word    <= '0;
            store_req    <= 1'b0;
            restore_req  <= 1'b0;
            read_req     <= 1'b0;
            read_addr    <= '0;
            lastaddr_req <= 1'b0;
            ctl_prog_en  <= 1'b0;
            ctl_wr_en    <= 1'b0;
            ctl_prog_ok  <= 1'b0;
        end else begin
            store_req    <= 1'b0;
            restore_req  <= 1'b0;
            read_req     <= 1'b0;
            lastaddr_req <= 1'b0;
            if (mem_prog_ok) ctl_prog_ok <= 1'b1;
            if (accept) begin
                resp_word <= '0;
                unique case (cmd)
                    CMD_WR_WIPER: if (open_gate && ctl_wr_en) wiper <= data;
                    CMD_RD_WIPER: resp_word <= WORD_W'(wiper);
                    CMD_STORE:    if (open_gate && ctl_prog_en) store_req <= 1'b1;
                    CMD_REFRESH: if (open_gate) begin
                        restore_req <= 1'b1;
                        shutdown    <= 1'b0;
                    end
                    CMD_RD_MEM: if (open_gate) begin
                        read_req  <= 1'b1;
                        read_addr <= data[AW-1:0];
                    end
                    CMD_RD_LAST:  if (open_gate) lastaddr_req <= 1'b1;
                    CMD_WR_CTRL: if (open_gate) begin
                        ctl_prog_en <= data[0];
                        ctl_wr_en   <= data[1];
                    end
                    CMD_RD_CTRL:
                        resp_word <= WORD_W'({ctl_prog_ok, 1'b0, ctl_wr_en, ctl_prog_en});
                    CMD_SHDN:     if (open_gate) shutdown <= data[0];
                    CMD_NOP: ;
                endcase
            end
            if (done_restore) wiper     <= mem_rdata;
            if (done_memrd)   resp_word <= WORD_W'(mem_rdata);
            if (done_addrrd)  resp_word <= WORD_W'(mem_rdata[AW-1:0]);
        end
    end
endmodule

// File: rtl/rheo_ctrl_chk.sv
module rheo_ctrl_chk #(
    parameter int DW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          word_vld,
    input logic [DW+5:0] word_in,
    input logic          mem_busy,
    input logic          mem_rvld,
    input logic [DW-1:0] wiper,
    input logic          shutdown,
    input logic          store_req,
    input logic          restore_req,
    input logic          read_req,
    input logic          lastaddr_req,
    input logic          prog_en,
    input logic          idle
);
    // R1 and R6 to R8: at most one memory request in any cycle
    assert_one_request_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_req, restore_req, read_req, lastaddr_req}));

    // R5: a store request follows only an accepted store frame with program enable set
    assert_store_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> $past(word_vld && word_in[DW+5:DW] == 6'd3 && prog_en && !mem_busy));

    // R2 and R6: the wiper changes only after a frame or a memory reply
    assert_wiper_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wiper) |-> $past(word_vld) || $past(mem_rvld));

    // R10: a frame taken while busy leaves wiper and shutdown untouched
    assert_busy_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && mem_busy && idle && !mem_rvld) |=> $stable(wiper) && $stable(shutdown));

    // R9: shutdown is entered only by a shutdown frame with data bit 0 set
    assert_shdn_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown) |-> $past(word_vld && word_in[DW+5:DW] == 6'd9 && word_in[0]));

    // R10: no request is raised by a frame seen while busy
    assert_busy_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && mem_busy) |=> !(store_req || restore_req || read_req || lastaddr_req));
endmodule

bind rheo_ctrl rheo_ctrl_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_vld     (word_vld),
    .word_in      (word_in),
    .mem_busy     (mem_busy),
    .mem_rvld     (mem_rvld),
    .wiper        (wiper),
    .shutdown     (shutdown),
    .store_req    (store_req),
    .restore_req  (restore_req),
    .read_req     (read_req),
    .lastaddr_req (lastaddr_req),
    .prog_en      (ctl_prog_en),
    .idle         (idle)
);

// File: tb/rheo_ctrl_test.sv
module rheo_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_vld = 1'b0;
    logic [15:0] word_in = '0;
    logic        mem_busy = 1'b0;
    logic        mem_prog_ok = 1'b0;
    logic        mem_rvld = 1'b0;
    logic [9:0]  mem_rdata = '0;
    logic [9:0]  wiper;
    logic        shutdown;
    logic [15:0] resp_word;
    logic        store_req, restore_req, read_req, lastaddr_req;
    logic [5:0]  read_addr;

    int n_chk = 0;
    int n_bad = 0;
    int exp_wiper = 512;

    always #10 clk = ~clk;

    rheo_ctrl uut (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_in(word_in),
        .mem_busy(mem_busy), .mem_prog_ok(mem_prog_ok), .mem_rvld(mem_rvld),
        .mem_rdata(mem_rdata), .wiper(wiper), .shutdown(shutdown),
        .resp_word(resp_word), .store_req(store_req), .restore_req(restore_req),
        .read_req(read_req), .read_addr(read_addr), .lastaddr_req(lastaddr_req)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] w);
        @(negedge clk);
        word_vld = 1'b1;
        word_in  = w;
        @(negedge clk);
        word_vld = 1'b0;
        word_in  = '0;
    endtask

    task automatic reply(input logic [9:0] d);
        @(negedge clk);
        mem_rvld  = 1'b1;
        mem_rdata = d;
        @(negedge clk);
        mem_rvld  = 1'b0;
    endtask

    task automatic t_reset;
        check(wiper == 10'd512, "R1 wiper", wiper, 512);
        check(shutdown == 1'b0, "R1 shutdown", shutdown, 0);
        check(resp_word == 16'h0, "R1 resp", resp_word, 0);
        check({store_req, restore_req, read_req, lastaddr_req} == 4'b0, "R1 requests",
              {store_req, restore_req, read_req, lastaddr_req}, 0);
        send(16'h2000);
        check(resp_word == 16'h0000, "R1 control default", resp_word, 0);
    endtask

    task automatic t_protect;
        send(16'h0455);
        check(wiper == 10'(exp_wiper), "R2 write while protected", wiper, exp_wiper);
    endtask

    task automatic t_control;
        send(16'h1C03);
        send(16'h2000);
        check(resp_word == 16'h0003, "R3 control read", resp_word, 3);
        @(negedge clk); mem_prog_ok = 1'b1;
        @(negedge clk); mem_prog_ok = 1'b0;
        send(16'h1C00);
        send(16'h2000);
        check(resp_word == 16'h0008, "R3 success bit kept", resp_word, 8);
        send(16'h1C03);
        send(16'h2000);
        check(resp_word == 16'h000B, "R3 control all set", resp_word, 16'hB);
    endtask

    task automatic t_write;
        send(16'h0500);
        exp_wiper = 16'h100;
        check(wiper == 10'h100, "R2 wiper write", wiper, 16'h100);
        send(16'h0800);
        check(resp_word == 16'h0100, "R4 wiper read", resp_word, 16'h100);
    endtask

    task automatic t_store;
        send(16'h0C00);
        check(store_req == 1'b1, "R5 store request", store_req, 1);
        @(negedge clk);
        check(store_req == 1'b0, "R5 store one cycle", store_req, 0);
        send(16'h1C02);
        send(16'h0C00);
        check(store_req == 1'b0, "R5 store disabled", store_req, 0);
        send(16'h1C03);
    endtask

    task automatic t_shutdown;
        send(16'h2401);
        check(shutdown == 1'b1, "R9 enter shutdown", shutdown, 1);
        send(16'h0420);
        exp_wiper = 16'h20;
        check(wiper == 10'h20, "R9 write in shutdown", wiper, 16'h20);
        send(16'h2400);
        check(shutdown == 1'b0, "R9 leave shutdown", shutdown, 0);
    endtask

    task automatic t_restore;
        send(16'h2401);
        send(16'h1C01);
        send(16'h1000);
        check(restore_req == 1'b1, "R6 restore request", restore_req, 1);
        check(shutdown == 1'b0, "R6 refresh leaves shutdown", shutdown, 0);
        reply(10'h2AA);
        exp_wiper = 16'h2AA;
        check(wiper == 10'h2AA, "R6 restore past protect", wiper, 16'h2AA);
        send(16'h1C03);
    endtask

    task automatic t_memread;
        send(16'h1414);
        check(read_req == 1'b1 && read_addr == 6'h14, "R7 read request",
              {read_req, read_addr}, {1'b1, 6'h14});
        reply(10'h155);
        check(resp_word == 16'h0155, "R7 location data", resp_word, 16'h155);
    endtask

    task automatic t_lastaddr;
        send(16'h1800);
        check(lastaddr_req == 1'b1, "R8 address request", lastaddr_req, 1);
        reply(10'h3D9);
        check(resp_word == 16'h0019, "R8 address reply", resp_word, 16'h19);
    endtask

    task automatic t_drop;
        send(16'h1800);
        send(16'h0477);
        check(wiper == 10'(exp_wiper), "R12 frame dropped while waiting", wiper, exp_wiper);
        check(resp_word == 16'h0, "R12 reply untouched", resp_word, 0);
        reply(10'h005);
        check(resp_word == 16'h0005, "R12 reply after wait", resp_word, 5);
    endtask

    task automatic t_busy;
        mem_busy = 1'b1;
        send(16'h0433);
        check(wiper == 10'(exp_wiper), "R10 wiper locked", wiper, exp_wiper);
        send(16'h2401);
        check(shutdown == 1'b0, "R10 shutdown locked", shutdown, 0);
        send(16'h1000);
        check(restore_req == 1'b0, "R10 refresh locked", restore_req, 0);
        send(16'h1C00);
        send(16'h2000);
        check(resp_word == 16'h000B, "R10 control locked, read served", resp_word, 16'hB);
        send(16'h0800);
        check(resp_word == 16'(exp_wiper), "R10 wiper read served", resp_word, exp_wiper);
        mem_busy = 1'b0;
    endtask

    task automatic t_nop;
        send(16'h2800);
        check(resp_word == 16'h0 && wiper == 10'(exp_wiper), "R11 code 10", resp_word, 0);
        send(16'h0800);
        send(16'h3FFF);
        check(resp_word == 16'h0 && wiper == 10'(exp_wiper) && !shutdown, "R11 code 15",
              resp_word, 0);
        send(16'h4433);
        check(wiper == 10'(exp_wiper), "R11 reserved bits set", wiper, exp_wiper);
        send(16'h0000);
        send(16'h2000);
        check(resp_word == 16'h000B, "R11 control untouched", resp_word, 16'hB);
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_protect();
        t_control();
        t_write();
        t_store();
        t_shutdown();
        t_restore();
        t_memread();
        t_lastaddr();
        t_drop();
        t_busy();
        t_nop();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule